// File: doc/BRIEF.md
# Register-Programmed Raster Timing Generator

This block is the timing core of a simple scan-out display controller. Software programs it through a small 32-bit register window. It then produces horizontal and vertical position counters, horizontal and vertical sync pulses with programmable polarity, a data-enable qualifier, and a byte address for each visible pixel. The pixel addresses start from a programmable frame-buffer base. A downstream fetch engine uses the address stream to read pixels from memory, and a display interface uses the syncs and data-enable.

All geometry values are packed two to a word. The horizontal quantity sits in the upper half and the vertical quantity in the lower half, and each is stored as its value minus one. Sync windows are not absolute positions. They are offsets counted from the first blanking pixel or line, which is the one that follows the visible area. The geometry, base and stride registers are shadowed. A write to the start-set register arms a reload, and the working copy changes only where the next frame begins, so a running picture never tears. While scan-out is disabled, the counters rest at zero and both syncs sit at their inactive levels.

Top module: `disp_timing_gen`

## Requirements
- R1: Writable registers read back what was written. Offsets are 0x000 control, 0x004 status, 0x010 total size, 0x014 hsync window, 0x018 vsync window, 0x01C blanking size, 0x040 base address and 0x050 stride. Each geometry word holds horizontal minus one in bits 31:16 and vertical minus one in bits 15:0.
- R2: While enabled, the horizontal counter runs from 0 to H_total−1 and then returns to 0. The vertical counter increments at each line end and wraps to 0 after line V_total−1. Here H_total and V_total are the total-size fields plus one.
- R3: Data-enable is high exactly when the horizontal count is below H_total−H_blank and the vertical count is below V_total−V_blank, where the blanking lengths are the blanking-size fields plus one.
- R4: Hsync is active when active_width+start_field+1 ≤ hcount < active_width+end_field+1, using the fields of the hsync register. Vsync follows the same rule on the vertical count with the vsync register. Control bit 4 makes hsync active-high and bit 3 makes vsync active-high. When a polarity bit is 0, that sync is active-low.
- R5: Geometry, base and stride writes do not affect the output until a write to 0x084 with bit 0 set. The new values take effect at the next frame start after the counters wrap to (0,0), or on the next clock if scan-out is disabled.
- R6: During data-enable, the pixel address equals base + vcount·line_step + hcount·bpp. The value bpp is 4 when control bit 2 is 1 and 2 when it is 0. The address value is defined only while data-enable is high.
- R7: line_step is the stride register when it is non-zero. When the stride is zero, line_step is the active width times bpp.
- R8: Status bit 1 reads 1 exactly while control bit 1 (scan enable) is set. All other status bits read 0.
- R9: Offset 0x3FC returns the fixed non-zero identity constant 0x5D7C0001.
- R10: While control bit 1 is clear, both counters are held at 0, data-enable is low and both syncs drive their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hcount | output | 16 | Horizontal position counter |
| vcount | output | 16 | Vertical position counter |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Visible-pixel qualifier |
| pix_addr | output | 32 | Byte address of the current visible pixel |

## Verification
A wrong counter state shows up on hcount and vcount in the same cycle. It then shifts data-enable and both sync windows, and the bench flags this on the next clock compare. A reload that happens at the wrong moment changes the line length in the middle of a frame. The bench catches this within one line, because its reference holds the old geometry until the frame boundary. An address accumulator that drifts is exposed at the next visible pixel, because the expected address comes from a closed-form product of position and step rather than from a running sum.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int REG_AW = 12;
  localparam int BUS_W  = 32;
  localparam int GEO_W  = 16;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h000;
  localparam logic [REG_AW-1:0] OFS_STAT   = 12'h004;
  localparam logic [REG_AW-1:0] OFS_TOTAL  = 12'h010;
  localparam logic [REG_AW-1:0] OFS_HSWIN  = 12'h014;
  localparam logic [REG_AW-1:0] OFS_VSWIN  = 12'h018;
  localparam logic [REG_AW-1:0] OFS_BLANK  = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_BASE   = 12'h040;
  localparam logic [REG_AW-1:0] OFS_STRIDE = 12'h050;
  localparam logic [REG_AW-1:0] OFS_START  = 12'h084;
  localparam logic [REG_AW-1:0] OFS_IDENT  = 12'h3FC;

  typedef struct packed {
    logic [GEO_W-1:0] h_tot;
    logic [GEO_W-1:0] v_tot;
    logic [GEO_W-1:0] h_blk;
    logic [GEO_W-1:0] v_blk;
    logic [GEO_W-1:0] hs_beg;
    logic [GEO_W-1:0] hs_fin;
    logic [GEO_W-1:0] vs_beg;
    logic [GEO_W-1:0] vs_fin;
    logic [BUS_W-1:0] base;
    logic [BUS_W-1:0] stride;
  } geom_t;

  // sync window: offsets are stored minus one and count from the first blank position
  function automatic logic in_window(logic [GEO_W-1:0] pos, logic [GEO_W-1:0] act,
                                     logic [GEO_W-1:0] beg, logic [GEO_W-1:0] fin);
    logic [GEO_W:0] lo;
    logic [GEO_W:0] hi;
    lo = {1'b0, act} + {1'b0, beg} + 1'b1;
    hi = {1'b0, act} + {1'b0, fin} + 1'b1;
    return ({1'b0, pos} >= lo) && ({1'b0, pos} < hi);
  endfunction

  function automatic logic [BUS_W-1:0] bytes_per_pix(logic wide);
    return wide ? BUS_W'(4) : BUS_W'(2);
  endfunction

  function automatic logic [BUS_W-1:0] line_step(logic [BUS_W-1:0] stride,
                                                 logic [GEO_W-1:0] act_w, logic wide);
    if (stride != '0) return stride;
    return BUS_W'(act_w) << (wide ? 2 : 1);
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter logic [BUS_W-1:0] ID_VALUE = 32'h5D7C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              frame_end,
  output logic              scan_en,
  output logic              fmt32,
  output logic              vs_pol,
  output logic              hs_pol,
  output geom_t             wk,
  output logic [BUS_W-1:0]  next_base,
  output logic              load_now
);
  geom_t sh;
  logic  pend;
  logic  start_hit;

  assign start_hit = wr_en && (addr == OFS_START) && wdata[0];
  assign load_now  = pend && (!scan_en || frame_end);
  assign next_base = load_now ? sh.base : wk.base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_en <= 1'b0;
      fmt32   <= 1'b0;
      vs_pol  <= 1'b0;
      hs_pol  <= 1'b0;
      sh      <= '0;
      wk      <= '0;
      pend    <= 1'b0;
    end else begin
      if (load_now) wk <= sh;
      if (start_hit)     pend <= 1'b1;
      else if (load_now) pend <= 1'b0;
      if (wr_en) begin
        case (addr)
          OFS_CTRL: begin
            scan_en <= wdata[1];
            fmt32   <= wdata[2];
            vs_pol  <= wdata[3];
            hs_pol  <= wdata[4];
          end
          OFS_TOTAL:  {sh.h_tot, sh.v_tot}   <= wdata;
          OFS_HSWIN:  {sh.hs_beg, sh.hs_fin} <= wdata;
          OFS_VSWIN:  {sh.vs_beg, sh.vs_fin} <= wdata;
          OFS_BLANK:  {sh.h_blk, sh.v_blk}   <= wdata;
          OFS_BASE:   sh.base                <= wdata;
          OFS_STRIDE: sh.stride              <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL:   rdata = {27'b0, hs_pol, vs_pol, fmt32, scan_en, 1'b0};
      OFS_STAT:   rdata = {30'b0, scan_en, 1'b0};
      OFS_TOTAL:  rdata = {sh.h_tot, sh.v_tot};
      OFS_HSWIN:  rdata = {sh.hs_beg, sh.hs_fin};
      OFS_VSWIN:  rdata = {sh.vs_beg, sh.vs_fin};
      OFS_BLANK:  rdata = {sh.h_blk, sh.v_blk};
      OFS_BASE:   rdata = sh.base;
      OFS_STRIDE: rdata = sh.stride;
      OFS_IDENT:  rdata = ID_VALUE;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  geom_t            g,
  input  logic             hs_pol,
  input  logic             vs_pol,
  output logic [GEO_W-1:0] hcnt,
  output logic [GEO_W-1:0] vcnt,
  output logic [GEO_W-1:0] act_w,
  output logic [GEO_W-1:0] act_h,
  output logic             de,
  output logic             hsync,
  output logic             vsync,
  output logic             line_end,
  output logic             frame_end
);
  logic hs_on;
  logic vs_on;

  assign act_w     = g.h_tot - g.h_blk;
  assign act_h     = g.v_tot - g.v_blk;
  assign line_end  = en && (hcnt == g.h_tot);
  assign frame_end = line_end && (vcnt == g.v_tot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign de    = en && (hcnt < act_w) && (vcnt < act_h);
  assign hs_on = en && in_window(hcnt, act_w, g.hs_beg, g.hs_fin);
  assign vs_on = en && in_window(vcnt, act_h, g.vs_beg, g.vs_fin);
  assign hsync = hs_on ? hs_pol : ~hs_pol;
  assign vsync = vs_on ? vs_pol : ~vs_pol;
endmodule

// File: rtl/dtg_addr.sv
module dtg_addr
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_end,
  input  logic             line_end,
  input  logic             de,
  input  logic             act_line,
  input  logic [BUS_W-1:0] next_base,
  input  logic [BUS_W-1:0] stride,
  input  logic [GEO_W-1:0] act_w,
  input  logic             fmt32,
  output logic [BUS_W-1:0] pix_addr
);
  logic [BUS_W-1:0] line_base;
  logic [BUS_W-1:0] lb_next;

  assign lb_next = line_base + (act_line ? line_step(stride, act_w, fmt32) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base <= '0;
      pix_addr  <= '0;
    end else if (!en || frame_end) begin
      line_base <= next_base;
      pix_addr  <= next_base;
    end else if (line_end) begin
      line_base <= lb_next;
      pix_addr  <= lb_next;
    end else if (de) begin
      pix_addr  <= pix_addr + bytes_per_pix(fmt32);
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter logic [BUS_W-1:0] ID_VALUE = 32'h5D7C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic [GEO_W-1:0]  hcount,
  output logic [GEO_W-1:0]  vcount,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [BUS_W-1:0]  pix_addr
);
  logic             scan_en, fmt32, vs_pol, hs_pol;
  geom_t            wk;
  logic [BUS_W-1:0] next_base;
  logic             load_now;
  logic [GEO_W-1:0] act_w, act_h;
  logic             line_end, frame_end;

  dtg_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_end(frame_end), .scan_en(scan_en), .fmt32(fmt32),
    .vs_pol(vs_pol), .hs_pol(hs_pol), .wk(wk), .next_base(next_base), .load_now(load_now)
  );

  dtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .en(scan_en), .g(wk), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hcnt(hcount), .vcnt(vcount), .act_w(act_w), .act_h(act_h), .de(de),
    .hsync(hsync), .vsync(vsync), .line_end(line_end), .frame_end(frame_end)
  );

  dtg_addr u_addr (
    .clk(clk), .rst_n(rst_n), .en(scan_en), .frame_end(frame_end), .line_end(line_end),
    .de(de), .act_line(vcount < act_h), .next_base(next_base), .stride(wk.stride),
    .act_w(act_w), .fmt32(fmt32), .pix_addr(pix_addr)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             fmt32,
  input logic             hs_pol,
  input logic             vs_pol,
  input logic [GEO_W-1:0] hcount,
  input logic [GEO_W-1:0] vcount,
  input logic [GEO_W-1:0] h_tot,
  input logic [BUS_W-1:0] total_word,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input logic [BUS_W-1:0] pix_addr
);
  assert_hcount_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hcount <= h_tot);

  assert_idle_counters_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (hcount == '0 && vcount == '0));

  assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (!de && hsync != hs_pol && vsync != vs_pol));

  assert_reload_at_frame_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(total_word) |-> (hcount == '0 && vcount == '0));

  assert_pixel_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && hcount == $past(hcount) + 1'b1) |->
      pix_addr == $past(pix_addr) + ($past(fmt32) ? 32'd4 : 32'd2));
endmodule

bind disp_timing_gen dtg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .fmt32(fmt32), .hs_pol(hs_pol),
  .vs_pol(vs_pol), .hcount(hcount), .vcount(vcount), .h_tot(wk.h_tot),
  .total_word({wk.h_tot, wk.v_tot}), .de(de), .hsync(hsync), .vsync(vsync),
  .pix_addr(pix_addr)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] hcount, vcount;
  logic        hsync, vsync, de;
  logic [31:0] pix_addr;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;

  // reference state: 0 htot,1 vtot,2 hblk,3 vblk,4 hs start,5 hs end,6 vs start,7 vs end
  int shg[8];
  int wkg[8];
  logic [31:0] sh_base = 0, sh_str = 0, wk_base = 0, wk_str = 0;
  int m_en = 0, m_fmt = 0, m_vp = 0, m_hp = 0, m_pend = 0, h = 0, v = 0, ld = 0;

  always #4 clk = ~clk;

  disp_timing_gen u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hcount(hcount), .vcount(vcount), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_addr(pix_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_fmt = 0; m_vp = 0; m_hp = 0; m_pend = 0; h = 0; v = 0;
    end else begin
      ld = (m_pend != 0 && (m_en == 0 || (h == wkg[0] && v == wkg[1]))) ? 1 : 0;
      if (m_en == 0) begin h = 0; v = 0; end
      else if (h == wkg[0]) begin h = 0; v = (v == wkg[1]) ? 0 : v + 1; end
      else h = h + 1;
      if (ld != 0) begin
        wkg = shg; wk_base = sh_base; wk_str = sh_str; m_pend = 0;
      end
      if (reg_wr) begin
        case (reg_addr)
          12'h000: begin
            m_en = reg_wdata[1]; m_fmt = reg_wdata[2]; m_vp = reg_wdata[3]; m_hp = reg_wdata[4];
          end
          12'h010: begin shg[0] = reg_wdata[31:16]; shg[1] = reg_wdata[15:0]; end
          12'h014: begin shg[4] = reg_wdata[31:16]; shg[5] = reg_wdata[15:0]; end
          12'h018: begin shg[6] = reg_wdata[31:16]; shg[7] = reg_wdata[15:0]; end
          12'h01C: begin shg[2] = reg_wdata[31:16]; shg[3] = reg_wdata[15:0]; end
          12'h040: sh_base = reg_wdata;
          12'h050: sh_str = reg_wdata;
          12'h084: if (reg_wdata[0]) m_pend = 1;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin : cmp
    int aw, ah, bpp;
    bit ede, hon, von, ehs, evs;
    logic [31:0] step, ea;
    if (cmp_on) begin
      aw = wkg[0] - wkg[2];
      ah = wkg[1] - wkg[3];
      bpp = (m_fmt != 0) ? 4 : 2;
      step = (wk_str != 0) ? wk_str : 32'(aw * bpp);
      ede = (m_en != 0) && h < aw && v < ah;
      hon = (m_en != 0) && h >= aw + wkg[4] + 1 && h < aw + wkg[5] + 1;
      von = (m_en != 0) && v >= ah + wkg[6] + 1 && v < ah + wkg[7] + 1;
      ehs = hon ? (m_hp != 0) : (m_hp == 0);
      evs = von ? (m_vp != 0) : (m_vp == 0);
      chk(hcount == 16'(h), "R2 hcount", 32'(hcount), 32'(h));
      chk(vcount == 16'(v), "R2 vcount", 32'(vcount), 32'(v));
      chk(de == ede, "R3 de", 32'(de), 32'(ede));
      chk(hsync == ehs, "R4 hsync", 32'(hsync), 32'(ehs));
      chk(vsync == evs, "R4 vsync", 32'(vsync), 32'(evs));
      if (ede) begin
        ea = wk_base + 32'(v) * step + 32'(h * bpp);
        chk(pix_addr == ea, "R6/R7 pix_addr", pix_addr, ea);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int hmax;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    #1;
    chk(hcount == 0 && vcount == 0, "R10 reset counters", 32'(hcount), 0);
    chk(!de && hsync && vsync, "R10 reset idle levels", {29'b0, de, hsync, vsync}, 32'h3);
    rd(12'h3FC, 32'h5D7C_0001, "R9 identity");
    rd(12'h004, 32'h0, "R8 status idle");
    rd(12'h000, 32'h0, "R1 control reset");

    // 20x8 total, 6x3 blank, hsync offsets 1..3, vsync offsets 0..1, packed 16-bit
    wr(12'h010, 32'h0013_0007);
    wr(12'h01C, 32'h0005_0002);
    wr(12'h014, 32'h0001_0003);
    wr(12'h018, 32'h0000_0001);
    wr(12'h040, 32'h0000_1000);
    wr(12'h050, 32'h0);
    wr(12'h084, 32'h1);
    rd(12'h010, 32'h0013_0007, "R1 total readback");
    rd(12'h01C, 32'h0005_0002, "R1 blank readback");
    rd(12'h040, 32'h0000_1000, "R1 base readback");
    wr(12'h000, 32'h12);
    rd(12'h004, 32'h2, "R8 status busy");
    rd(12'h000, 32'h12, "R1 control readback");
    repeat (330) @(negedge clk);

    // mid-frame reload request: new size applies only at the next frame start
    wr(12'h010, 32'h0017_0009);
    wr(12'h040, 32'h0000_2000);
    wr(12'h084, 32'h1);
    repeat (500) @(negedge clk);

    // geometry write without the start strobe must not change the line length
    wr(12'h010, 32'h001F_0009);
    hmax = 0;
    repeat (300) begin
      @(negedge clk);
      if (int'(hcount) > hmax) hmax = int'(hcount);
    end
    chk(hmax == 23, "R5 unarmed write ignored", 32'(hmax), 32'd23);

    // disable, then reprogram with a stride and 32-bit pixels
    wr(12'h000, 32'h0);
    repeat (5) @(negedge clk);
    chk(hcount == 0 && vcount == 0 && !de, "R10 held while disabled", 32'(hcount), 0);
    chk(hsync && vsync, "R10 inactive syncs", {30'b0, hsync, vsync}, 32'h3);
    rd(12'h004, 32'h0, "R8 status after disable");
    wr(12'h010, 32'h0013_0007);
    wr(12'h050, 32'h0000_0064);
    wr(12'h040, 32'h0000_3000);
    wr(12'h084, 32'h1);
    wr(12'h000, 32'h0E);
    while (!(vcount == 1 && hcount == 0)) @(negedge clk);
    chk(de && pix_addr == 32'h3064, "R7 stride line start", pix_addr, 32'h3064);
    repeat (400) @(negedge clk);

    // packed 32-bit lines with active-high hsync
    wr(12'h050, 32'h0);
    wr(12'h084, 32'h1);
    wr(12'h000, 32'h16);
    repeat (400) @(negedge clk);
    finish_run();
  end
endmodule